// File: doc/BRIEF.md
# Single-Round VOQ Crossbar Matcher

This block picks, once per time slot, which input of an N x N input-queued crossbar may send a cell to which output. Every input holds one virtual output queue per output, and the block sees one busy flag for each of these queues. In every slot it runs a single request, grant and accept round and registers a legal matching. The matching is returned as one one-hot row per input, together with a one-cycle valid strobe.

Requests are ranked by how long their queue has been waiting. The block keeps a wrap-aware timestamp of the slot in which each queue last became busy, and older requests win. A pair that was matched in one slot is treated as a strong request in the next slot. Because of this the matching is carried forward rather than rebuilt from nothing, and a single round per slot can still grow it over successive slots. The port count defaults to 16 and the stamp width to 8 bits.

Top module: `voq_match_sched`

## Requirements
- R1: A pulse on `slot_start_i` runs exactly one round. The resulting matching appears on `match_o`, with `match_valid_o` high, on the cycle after the pulse. `match_valid_o` is low on every other cycle, and `match_o` holds its value until the next pulse.
- R2: Bit `i*N+j` of `voq_busy_i` and of `match_o` refers to input i and output j. A pair can be matched only if its busy bit was set in the slot-start cycle.
- R3: In every cycle, each input row of `match_o` has at most one bit set and each output column has at most one bit set.
- R4: At the grant stage, each output grants the requesting input whose queue has the earliest activation stamp.
- R5: At the accept stage, each input accepts, among the outputs that granted it, the one whose queue has the earliest activation stamp.
- R6: The stamp of a queue is the value of a slot counter taken in the cycle its busy bit goes from 0 to 1. The counter starts at zero and advances on each slot pulse. The stamp stays fixed while the bit stays at 1. A queue that drains and refills takes a new stamp.
- R7: When strength and stamp are equal, the lower port index wins at both stages.
- R8: A pair matched in a slot becomes strong for the next slot. A strong request beats an ordinary one at both stages, even one with an earlier stamp. A strong pair whose queue is still busy is matched again.
- R9: The strong mark of a queue is cleared as soon as its busy bit drops, and it is cleared when the pair is not matched in a slot.
- R10: Stamps are compared modulo 2^TS_W. Stamp a is earlier than b when bit TS_W-1 of (a-b) is set, so ordering stays correct across the counter wrap.
- R11: During and right after reset, `match_o` is zero, `match_valid_o` is low, the slot counter is zero and no queue is strong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_start_i | input | 1 | Pulse that starts a scheduling round |
| voq_busy_i | input | N_PORTS*N_PORTS | Busy flag of each virtual output queue, bit i*N+j = input i to output j |
| match_o | output | N_PORTS*N_PORTS | Registered matching, one one-hot row per input |
| match_valid_o | output | 1 | High for one cycle when a new matching is on match_o |

## Verification
The hardest case to reach from the ports is a strong pair that must win against an ordinary request with an earlier stamp. A single earliest-first round only creates that conflict after a specific history. First, an output is held by one input through a strong pair while a second input's queue to that output waits. Next, the second input wins a different output with a younger queue. Then the first holder drains, so the second input is offered both its older ordinary grant and its younger strong one. The stamp wrap is reached with a narrow stamp width: an older queue is kept waiting behind a strong pair until the counter rolls past zero, and then a fresh competitor arrives whose raw stamp is numerically smaller.

// File: rtl/vsched_pkg.sv
package vsched_pkg;
  localparam int unsigned DEF_PORTS = 16;
  localparam int unsigned DEF_TS_W  = 8;

  // serial-number order on w-bit stamps carried in 32-bit containers
  function automatic logic ts_before(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction
endpackage

// File: rtl/vsched_pick.sv
module vsched_pick
  import vsched_pkg::*;
#(
  parameter int unsigned N    = DEF_PORTS,
  parameter int unsigned TS_W = DEF_TS_W
) (
  input  logic [N-1:0]      valid_i,
  input  logic [N-1:0]      strong_i,
  input  logic [N*TS_W-1:0] ts_i,
  output logic [N-1:0]      pick_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic              found;
  logic              best_s;
  logic [TS_W-1:0]   best_t;
  logic [IDX_W-1:0]  sel;

  always_comb begin
    found  = 1'b0;
    best_s = 1'b0;
    best_t = '0;
    sel    = '0;
    pick_o = '0;
    for (int k = 0; k < N; k++) begin
      if (valid_i[k]) begin
        // strictly better only: equal keys keep the lower index
        if (!found || (strong_i[k] && !best_s) ||
            ((strong_i[k] == best_s) &&
             ts_before(32'(ts_i[k*TS_W +: TS_W]), 32'(best_t), TS_W))) begin
          found  = 1'b1;
          best_s = strong_i[k];
          best_t = ts_i[k*TS_W +: TS_W];
          sel    = IDX_W'(k);
        end
      end
    end
    if (found) pick_o[sel] = 1'b1;
  end
endmodule

// File: rtl/vsched_stamp.sv
module vsched_stamp
  import vsched_pkg::*;
#(
  parameter int unsigned NV   = DEF_PORTS * DEF_PORTS,
  parameter int unsigned TS_W = DEF_TS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               slot_start_i,
  input  logic [NV-1:0]      busy_i,
  input  logic [NV-1:0]      match_next_i,
  input  logic [TS_W-1:0]    slot_cnt_i,
  output logic [NV*TS_W-1:0] ts_o,
  output logic [NV-1:0]      strong_o
);
  logic [NV-1:0]   occ_q;
  logic [NV-1:0]   strong_q;
  logic [TS_W-1:0] ts_q [NV];

  // a queue turning busy this cycle already ranks with the current count
  always_comb begin
    for (int k = 0; k < NV; k++) begin
      ts_o[k*TS_W +: TS_W] = (busy_i[k] && !occ_q[k]) ? slot_cnt_i : ts_q[k];
    end
  end

  assign strong_o = strong_q & busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q    <= '0;
      strong_q <= '0;
      for (int k = 0; k < NV; k++) ts_q[k] <= '0;
    end else begin
      occ_q    <= busy_i;
      strong_q <= slot_start_i ? (match_next_i & busy_i) : strong_o;
      for (int k = 0; k < NV; k++) ts_q[k] <= ts_o[k*TS_W +: TS_W];
    end
  end

  for (genvar k = 0; k < NV; k++) begin : g_chk
    // R6
    ts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i[k] && occ_q[k]) |=> (ts_q[k] == $past(ts_q[k])));
    // R9
    strong_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_i[k] |=> !strong_q[k]);
  end
endmodule

// File: rtl/voq_match_sched.sv
module voq_match_sched
  import vsched_pkg::*;
#(
  parameter int unsigned N_PORTS = DEF_PORTS,
  parameter int unsigned TS_W    = DEF_TS_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         slot_start_i,
  input  logic [N_PORTS*N_PORTS-1:0]   voq_busy_i,
  output logic [N_PORTS*N_PORTS-1:0]   match_o,
  output logic                         match_valid_o
);
  localparam int unsigned N  = N_PORTS;
  localparam int unsigned NV = N_PORTS * N_PORTS;

  logic [TS_W-1:0]    slot_cnt_q;
  logic [NV*TS_W-1:0] ts_eff;
  logic [NV-1:0]      strong_eff;
  logic [NV-1:0]      match_next;
  logic [N-1:0]       gnt_oi [N];   // [output][input]
  logic [NV-1:0]      match_q;
  logic               valid_q;

  vsched_stamp #(.NV(NV), .TS_W(TS_W)) u_stamp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_start_i (slot_start_i),
    .busy_i       (voq_busy_i),
    .match_next_i (match_next),
    .slot_cnt_i   (slot_cnt_q),
    .ts_o         (ts_eff),
    .strong_o     (strong_eff)
  );

  // grant stage: one arbiter per output over the inputs
  for (genvar o = 0; o < N; o++) begin : g_gnt
    logic [N-1:0]      cand_v;
    logic [N-1:0]      cand_s;
    logic [N*TS_W-1:0] cand_t;
    always_comb begin
      for (int i = 0; i < N; i++) begin
        cand_v[i] = voq_busy_i[i*N+o];
        cand_s[i] = strong_eff[i*N+o];
        cand_t[i*TS_W +: TS_W] = ts_eff[(i*N+o)*TS_W +: TS_W];
      end
    end
    vsched_pick #(.N(N), .TS_W(TS_W)) u_pick (
      .valid_i  (cand_v),
      .strong_i (cand_s),
      .ts_i     (cand_t),
      .pick_o   (gnt_oi[o])
    );
  end

  // accept stage: one arbiter per input over its grants
  for (genvar i = 0; i < N; i++) begin : g_acc
    logic [N-1:0] got_v;
    always_comb begin
      for (int o = 0; o < N; o++) got_v[o] = gnt_oi[o][i];
    end
    vsched_pick #(.N(N), .TS_W(TS_W)) u_pick (
      .valid_i  (got_v),
      .strong_i (strong_eff[i*N +: N]),
      .ts_i     (ts_eff[i*N*TS_W +: N*TS_W]),
      .pick_o   (match_next[i*N +: N])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_cnt_q <= '0;
      match_q    <= '0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= slot_start_i;
      if (slot_start_i) begin
        slot_cnt_q <= slot_cnt_q + 1'b1;
        match_q    <= match_next;
      end
    end
  end

  assign match_o       = match_q;
  assign match_valid_o = valid_q;

  // R1
  match_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_valid_o |-> $stable(match_o));
  // R2
  match_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_valid_o |-> ((match_o & ~$past(voq_busy_i)) == '0));

  for (genvar p = 0; p < N; p++) begin : g_legal
    logic [N-1:0] col_v;
    always_comb begin
      for (int i = 0; i < N; i++) col_v[i] = match_o[i*N+p];
    end
    // R3
    row_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(match_o[p*N +: N]));
    // R3
    col_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col_v));
  end

  for (genvar k = 0; k < NV; k++) begin : g_keep
    // R8
    strong_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_start_i && strong_eff[k]) |=> match_o[k]);
  end
endmodule

// File: tb/voq_match_sched_tb_top.sv
module voq_match_sched_tb_top;
  localparam int unsigned N          = 4;
  localparam int unsigned TW         = 4;
  localparam int unsigned NV         = N * N;
  localparam time         CLK_PERIOD = 10ns;
  localparam int          NVEC       = 6;

  // {voq_busy, expected match}, slots run back to back after reset
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0013, 16'h0001},   // R4 R7: out0 tie goes to in0
    {16'h0033, 16'h0001},   // R8: strong (0,0) kept
    {16'h0032, 16'h0012},   // R5 R9: (0,0) drained
    {16'h0332, 16'h0012},   // R8: both strong pairs kept
    {16'h0322, 16'h0102},   // R4 R6: in2 stamp 3 gets out0
    {16'h0000, 16'h0000}    // R2: nothing busy
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          slot_start;
  logic [NV-1:0] voq_busy;
  logic [NV-1:0] match;
  logic          match_valid;
  int            n_checks = 0;
  int            n_fail   = 0;
  bit            done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voq_match_sched #(.N_PORTS(N), .TS_W(TW)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .slot_start_i  (slot_start),
    .voq_busy_i    (voq_busy),
    .match_o       (match),
    .match_valid_o (match_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic legal(input logic [NV-1:0] m);
    for (int p = 0; p < N; p++) begin
      int r = 0;
      int c = 0;
      for (int q = 0; q < N; q++) begin
        r += int'(m[p*N+q]);
        c += int'(m[q*N+p]);
      end
      if (r > 1 || c > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic do_reset();
    rst_n      = 1'b0;
    slot_start = 1'b0;
    voq_busy   = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_slot(input logic [NV-1:0] v);
    @(negedge clk);
    voq_busy   = v;
    slot_start = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
  endtask

  task automatic slot_check(input string req, input logic [NV-1:0] v, input logic [NV-1:0] exp);
    run_slot(v);
    check({req, " match"}, 32'(match), 32'(exp));
    check("R1 valid strobe", 32'(match_valid), 32'd1);
    check("R2 subset of busy", 32'(match & ~v), 32'd0);
    check("R3 legal", 32'(legal(match)), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11
    check("R11 reset match", 32'(match), 32'd0);
    check("R11 reset valid", 32'(match_valid), 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      slot_check("R4 R5 R8 table", VEC[k][31:16], VEC[k][15:0]);
    end

    // R1: result held, no strobe between slots
    slot_check("R1 fresh", 16'h0001, 16'h0001);
    voq_busy = '0;
    @(negedge clk);
    check("R1 idle valid", 32'(match_valid), 32'd0);
    check("R1 idle hold", 32'(match), 32'h0001);

    // R9 R6: drained strong queue refills with a fresh stamp, tie -> in0
    do_reset();
    slot_check("R9 setup", 16'h0010, 16'h0010);
    voq_busy = '0;
    slot_check("R9 R6 R7 refill", 16'h0011, 16'h0001);

    // R8: strong out1 beats older ordinary grant out0 at accept
    do_reset();
    slot_check("R8 a", 16'h0010, 16'h0010);
    slot_check("R8 b", 16'h0011, 16'h0010);
    slot_check("R8 c", 16'h0013, 16'h0012);
    slot_check("R8 strong over older", 16'h0003, 16'h0002);

    // R10: (0,0) stamped 14, (1,0) stamped 1 after wrap; 14 is older
    do_reset();
    for (int s = 0; s < 18; s++) begin
      logic [NV-1:0] v;
      v = (s < 14) ? 16'h0002 : (s < 17) ? 16'h0003 : 16'h0013;
      run_slot(v);
      if (s == 16) check("R10 before wrap", 32'(match), 32'h0002);
      if (s == 17) check("R10 wrap order", 32'(match), 32'h0002);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule